// File: doc/BRIEF.md
# Address Translation Buffer with Address-Space Tags

This block is a small, fully associative translation buffer that turns a virtual address into a physical address. It uses 4 KB pages. The low 12 bits of the virtual address are the page offset and pass through unchanged. The bits above them form the virtual page number (VPN). Every entry stores:

- a VPN and an address-space tag (ASID);
- a global flag that makes the entry match under any ASID;
- a physical frame number (PFN);
- a read-allowed flag and a write-allowed flag;
- a valid bit;
- a used bit and a dirty bit.

A lookup is purely combinational. The result comes back in the same cycle as a hit, a protection fault, or a miss, together with the translated address. On a lookup that hits cleanly, the matched entry's used bit is set at the next clock edge. If the lookup is a write, its dirty bit is set as well.

Entries are loaded through a refill port, driven by software or by an external table walker. The slot for a new entry is chosen in this order:

1. If the new entry would overlap resident entries, it takes the place of those entries.
2. Otherwise it fills the lowest free slot.
3. If there is no free slot, it evicts a slot picked by a free-running pseudo-random generator.

Two invalidate controls flush either every entry or the non-global entries of one address space.

Top module: `tlb_asid_xlate`

## Requirements
- R1: After reset no entry is valid, and every lookup returns lk_hit=0, lk_fault=0, lk_pa=0, lk_used=0 and lk_dirty=0.
- R2: With lk_en=1, a lookup hits when a valid entry holds VPN = lk_va[31:12] and either has its global flag set or holds an ASID equal to cur_asid. The hit shows in the same cycle, with lk_pa = {PFN, lk_va[11:0]}.
- R3: A read (lk_write=0) needs the entry's read-allowed flag and a write (lk_write=1) needs its write-allowed flag. A match that lacks the needed flag gives lk_fault=1, lk_hit=0 and lk_pa=0.
- R4: A lookup that finds no match, or any cycle with lk_en=0, gives all-zero lookup outputs and changes no entry state.
- R5: On a hit or a fault, lk_used and lk_dirty show the matched entry's used and dirty bits as they stood before this access.
- R6: A clean hit sets the entry's used bit at the next edge. A clean write hit also sets its dirty bit. A fault changes neither bit.
- R7: A refill (rf_en=1) is written at the next edge, starts with used=0 and dirty=0, and can be looked up from the following cycle. It is not visible in the cycle it is presented.
- R8: A refill overlaps a valid entry when both hold the same VPN and either one is global or their ASIDs are equal. An overlapping refill removes every entry it overlaps and takes one of their slots. No other entry is evicted, so a lookup never sees two matches.
- R9: A refill with no overlap goes into the lowest-numbered invalid slot when one exists, evicting nothing.
- R10: When every slot is valid, a refill with no overlap takes the slot named by a free-running 16-bit LFSR that advances every cycle. It evicts exactly one resident entry.
- R11: inv_all=1 clears every valid bit at the next edge.
- R12: inv_asid_en=1 clears, at the next edge, the valid non-global entries whose ASID equals inv_asid. Global entries and entries of other ASIDs stay.
- R13: A refill presented in a cycle with inv_all or inv_asid_en asserted is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_asid | input | ASID_W | ASID of the running process |
| lk_en | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_va | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Clean translation |
| lk_fault | output | 1 | Match without the needed permission |
| lk_pa | output | PFN_W+PAGE_OFF_W | Physical address, zero unless lk_hit |
| lk_used | output | 1 | Matched entry's used bit before the access |
| lk_dirty | output | 1 | Matched entry's dirty bit before the access |
| rf_en | input | 1 | Write a new entry |
| rf_vpn | input | VA_W-PAGE_OFF_W | VPN of the new entry |
| rf_asid | input | ASID_W | ASID of the new entry |
| rf_global | input | 1 | New entry matches under any ASID |
| rf_pfn | input | PFN_W | Frame number of the new entry |
| rf_rd_ok | input | 1 | New entry allows reads |
| rf_wr_ok | input | 1 | New entry allows writes |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate non-global entries of inv_asid |
| inv_asid | input | ASID_W | ASID to invalidate |

## Verification
The bench builds the block with ENTRIES=4 and ASID_W=4, keeping the 32-bit address, the 12-bit offset and the 20-bit frame number.

With only four slots, a few refills are enough to fill the buffer. That makes the free-slot fill, the single random eviction on a full buffer, and the reuse of overlapping slots all reachable and countable from the ports. Overlap cases that mix global and per-ASID entries can also hold all their entries at once, so the number of surviving entries can be counted as well.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Access rights held by one entry
  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
  } tlb_perm_t;

  // Where a refill is placed
  typedef enum logic [1:0] {
    SLOT_REUSE  = 2'd0,
    SLOT_FREE   = 2'd1,
    SLOT_RANDOM = 2'd2
  } tlb_slot_src_e;

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int          ENTRIES   = 16,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [$clog2(ENTRIES)-1:0] rnd_idx
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [IDX_W-1:0]  raw_idx;
  logic              lfsr_unused;

  // Galois step, right shift
  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
    if (lfsr_q[0]) lfsr_d = lfsr_d ^ LFSR_TAPS[LFSR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= {{(LFSR_W-1){1'b0}}, 1'b1};
    else        lfsr_q <= lfsr_d;
  end

  // Fold the low bits into range when ENTRIES is not a power of two
  always_comb begin
    raw_idx = lfsr_q[IDX_W-1:0];
    if ({1'b0, raw_idx} >= (IDX_W+1)'(ENTRIES)) rnd_idx = raw_idx - IDX_W'(ENTRIES);
    else                                        rnd_idx = raw_idx;
  end

  assign lfsr_unused = ^lfsr_q[LFSR_W-1:IDX_W];

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [ENTRIES-1:0]             ent_glob,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic                           key_glob,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           hit_any,
  output logic [$clog2(ENTRIES)-1:0]     hit_idx
);

  localparam int IDX_W = $clog2(ENTRIES);

  // One comparator per slot; a global key or entry ignores the ASID
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) &&
                        (ent_glob[i] || key_glob || (ent_asid[i] == key_asid));
  end

  assign hit_any = |hit_vec;

  // Lowest matching slot wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic                           clk,
  input  logic                           rst_n,
  // refill write
  input  logic                           wr_go,
  input  logic [$clog2(ENTRIES)-1:0]     wr_idx,
  input  logic [ENTRIES-1:0]             wr_kill,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic [ASID_W-1:0]              wr_asid,
  input  logic                           wr_glob,
  input  logic [PFN_W-1:0]               wr_pfn,
  input  tlb_perm_t                      wr_perm,
  // invalidation
  input  logic                           inv_all,
  input  logic                           inv_asid_en,
  input  logic [ASID_W-1:0]              inv_asid,
  // status update from a clean access
  input  logic                           touch_go,
  input  logic [$clog2(ENTRIES)-1:0]     touch_idx,
  input  logic                           touch_wr,
  // entry contents
  output logic [ENTRIES-1:0]             ent_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  output logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  output logic [ENTRIES-1:0]             ent_glob,
  output logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn,
  output tlb_perm_t [ENTRIES-1:0]        ent_perm,
  output logic [ENTRIES-1:0]             ent_used,
  output logic [ENTRIES-1:0]             ent_dirty
);

  localparam int IDX_W = $clog2(ENTRIES);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              v_q, v_d, u_q, u_d, d_q, d_d, load;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic              glob_q;
    logic [PFN_W-1:0]  pfn_q;
    tlb_perm_t         perm_q;

    // Next state: touch, then refill, then invalidation overrides
    always_comb begin
      load = wr_go && (wr_idx == IDX_W'(i));
      v_d  = v_q;
      u_d  = u_q;
      d_d  = d_q;
      if (touch_go && (touch_idx == IDX_W'(i))) begin
        u_d = 1'b1;
        if (touch_wr) d_d = 1'b1;
      end
      if (wr_go && wr_kill[i]) v_d = 1'b0;
      if (load) begin
        v_d = 1'b1;
        u_d = 1'b0;
        d_d = 1'b0;
      end
      if (inv_all) v_d = 1'b0;
      if (inv_asid_en && !glob_q && (asid_q == inv_asid)) v_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        u_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        v_q <= v_d;
        u_q <= u_d;
        d_q <= d_d;
      end
    end

    // Payload: enabled load only, no reset
    always_ff @(posedge clk) begin
      if (load) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        glob_q <= wr_glob;
        pfn_q  <= wr_pfn;
        perm_q <= wr_perm;
      end
    end

    assign ent_valid[i] = v_q;
    assign ent_vpn[i]   = vpn_q;
    assign ent_asid[i]  = asid_q;
    assign ent_glob[i]  = glob_q;
    assign ent_pfn[i]   = pfn_q;
    assign ent_perm[i]  = perm_q;
    assign ent_used[i]  = u_q;
    assign ent_dirty[i] = d_q;

    // R6
    dirty_implies_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && d_q) |-> u_q);
  end

endmodule

// File: rtl/tlb_asid_xlate.sv
module tlb_asid_xlate
  import tlb_pkg::*;
#(
  parameter int          ENTRIES    = 16,
  parameter int          ASID_W     = 8,
  parameter int          VA_W       = 32,
  parameter int          PAGE_OFF_W = 12,
  parameter int          PFN_W      = 20,
  parameter int          LFSR_W     = 16,
  parameter logic [15:0] LFSR_TAPS  = 16'hB400
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ASID_W-1:0]           cur_asid,
  input  logic                        lk_en,
  input  logic                        lk_write,
  input  logic [VA_W-1:0]             lk_va,
  output logic                        lk_hit,
  output logic                        lk_fault,
  output logic [PFN_W+PAGE_OFF_W-1:0] lk_pa,
  output logic                        lk_used,
  output logic                        lk_dirty,
  input  logic                        rf_en,
  input  logic [VA_W-PAGE_OFF_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0]           rf_asid,
  input  logic                        rf_global,
  input  logic [PFN_W-1:0]            rf_pfn,
  input  logic                        rf_rd_ok,
  input  logic                        rf_wr_ok,
  input  logic                        inv_all,
  input  logic                        inv_asid_en,
  input  logic [ASID_W-1:0]           inv_asid
);

  localparam int VPN_W = VA_W - PAGE_OFF_W;
  localparam int PA_W  = PFN_W + PAGE_OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic                           rst_q_n;
  logic [ENTRIES-1:0]             ent_valid, ent_glob, ent_used, ent_dirty;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
  tlb_perm_t [ENTRIES-1:0]        ent_perm;

  logic [ENTRIES-1:0] lk_vec, ov_vec;
  logic               lk_any, ov_any, free_any;
  logic [IDX_W-1:0]   lk_idx, ov_idx, free_idx, rnd_idx, wr_idx;
  logic               perm_ok, rf_go;
  tlb_slot_src_e      slot_src;
  tlb_perm_t          rf_perm;

  tlb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tlb_victim_pick #(
    .ENTRIES   (ENTRIES),
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rnd_idx (rnd_idx)
  );

  // Lookup match under the current address space
  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_asid  (ent_asid),
    .ent_glob  (ent_glob),
    .key_vpn   (lk_va[VA_W-1:PAGE_OFF_W]),
    .key_asid  (cur_asid),
    .key_glob  (1'b0),
    .hit_vec   (lk_vec),
    .hit_any   (lk_any),
    .hit_idx   (lk_idx)
  );

  // Overlap search for the refill
  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_ov (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_asid  (ent_asid),
    .ent_glob  (ent_glob),
    .key_vpn   (rf_vpn),
    .key_asid  (rf_asid),
    .key_glob  (rf_global),
    .hit_vec   (ov_vec),
    .hit_any   (ov_any),
    .hit_idx   (ov_idx)
  );

  // Lowest invalid slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end
  assign free_any = !(&ent_valid);

  // Placement: overlap, then vacancy, then random victim
  always_comb begin
    if (ov_any)        slot_src = SLOT_REUSE;
    else if (free_any) slot_src = SLOT_FREE;
    else               slot_src = SLOT_RANDOM;
    case (slot_src)
      SLOT_REUSE: wr_idx = ov_idx;
      SLOT_FREE:  wr_idx = free_idx;
      default:    wr_idx = rnd_idx;
    endcase
  end

  assign rf_go   = rf_en && !inv_all && !inv_asid_en;
  assign rf_perm = '{rd_ok: rf_rd_ok, wr_ok: rf_wr_ok};

  // Lookup result
  assign perm_ok  = lk_write ? ent_perm[lk_idx].wr_ok : ent_perm[lk_idx].rd_ok;
  assign lk_hit   = lk_en && lk_any && perm_ok;
  assign lk_fault = lk_en && lk_any && !perm_ok;
  assign lk_pa    = lk_hit ? {ent_pfn[lk_idx], lk_va[PAGE_OFF_W-1:0]} : {PA_W{1'b0}};
  assign lk_used  = lk_en && lk_any && ent_used[lk_idx];
  assign lk_dirty = lk_en && lk_any && ent_dirty[lk_idx];

  tlb_entry_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W),
    .PFN_W   (PFN_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .wr_go       (rf_go),
    .wr_idx      (wr_idx),
    .wr_kill     (ov_vec),
    .wr_vpn      (rf_vpn),
    .wr_asid     (rf_asid),
    .wr_glob     (rf_global),
    .wr_pfn      (rf_pfn),
    .wr_perm     (rf_perm),
    .inv_all     (inv_all),
    .inv_asid_en (inv_asid_en),
    .inv_asid    (inv_asid),
    .touch_go    (lk_hit),
    .touch_idx   (lk_idx),
    .touch_wr    (lk_write),
    .ent_valid   (ent_valid),
    .ent_vpn     (ent_vpn),
    .ent_asid    (ent_asid),
    .ent_glob    (ent_glob),
    .ent_pfn     (ent_pfn),
    .ent_perm    (ent_perm),
    .ent_used    (ent_used),
    .ent_dirty   (ent_dirty)
  );

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(lk_vec));

  // R3
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(lk_hit && lk_fault));

  // R11
  inv_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    inv_all |=> (!lk_hit && !lk_fault));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !lk_en |-> (!lk_hit && !lk_fault && !lk_used && !lk_dirty));

endmodule

// File: tb/test_tlb_asid_xlate.sv
module test_tlb_asid_xlate;

  localparam int ENT   = 4;
  localparam int AW    = 4;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int PFN_W = 20;
  localparam int PA_W  = PFN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [AW-1:0]    cur_asid;
  logic             lk_en, lk_write;
  logic [VA_W-1:0]  lk_va;
  logic             lk_hit, lk_fault, lk_used, lk_dirty;
  logic [PA_W-1:0]  lk_pa;
  logic             rf_en, rf_global, rf_rd_ok, rf_wr_ok;
  logic [19:0]      rf_vpn;
  logic [AW-1:0]    rf_asid;
  logic [PFN_W-1:0] rf_pfn;
  logic             inv_all, inv_asid_en;
  logic [AW-1:0]    inv_asid;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tlb_asid_xlate #(.ENTRIES(ENT), .ASID_W(AW)) i_tlb_asid_xlate (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_en(lk_en),
    .lk_write(lk_write), .lk_va(lk_va), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_pa(lk_pa), .lk_used(lk_used), .lk_dirty(lk_dirty), .rf_en(rf_en),
    .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_global(rf_global), .rf_pfn(rf_pfn),
    .rf_rd_ok(rf_rd_ok), .rf_wr_ok(rf_wr_ok), .inv_all(inv_all),
    .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One lookup cycle; results sampled 1 ns after the inputs settle
  task automatic probe(input logic [31:0] va, input logic wr, input logic [AW-1:0] asid,
                       output logic hit, output logic flt, output logic [PA_W-1:0] pa,
                       output logic used, output logic dirty);
    lk_en = 1'b1; lk_va = va; lk_write = wr; cur_asid = asid;
    #1;
    hit = lk_hit; flt = lk_fault; pa = lk_pa; used = lk_used; dirty = lk_dirty;
    @(posedge clk); @(negedge clk);
    lk_en = 1'b0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [AW-1:0] asid, input logic g,
                        input logic [PFN_W-1:0] pfn, input logic r, input logic w);
    rf_en = 1'b1; rf_vpn = vpn; rf_asid = asid; rf_global = g; rf_pfn = pfn;
    rf_rd_ok = r; rf_wr_ok = w;
    @(posedge clk); @(negedge clk);
    rf_en = 1'b0;
  endtask

  task automatic flush();
    inv_all = 1'b1;
    @(posedge clk); @(negedge clk);
    inv_all = 1'b0;
  endtask

  // Packs the five lookup outputs into one value for comparison
  function automatic logic [63:0] pack(input logic h, input logic f, input logic [PA_W-1:0] p,
                                       input logic u, input logic d);
    return {28'd0, h, f, u, d, p};
  endfunction

  task automatic t_reset();
    logic h, f, u, d; logic [PA_W-1:0] p;
    probe(32'h1234_5678, 1'b0, 4'd0, h, f, p, u, d);
    check("R1 reset lookup", pack(h, f, p, u, d), 64'd0);
  endtask

  task automatic t_translate();
    logic h, f, u, d; logic [PA_W-1:0] p;
    flush();
    refill(20'h12345, 4'd3, 1'b0, 20'hABCDE, 1'b1, 1'b1);
    probe(32'h1234_5678, 1'b0, 4'd3, h, f, p, u, d);
    check("R2 asid hit", pack(h, f, p, u, d), pack(1, 0, 32'hABCD_E678, 0, 0));
    probe(32'h1234_5678, 1'b0, 4'd4, h, f, p, u, d);
    check("R4 other asid miss", pack(h, f, p, u, d), 64'd0);
    probe(32'h1234_6678, 1'b0, 4'd3, h, f, p, u, d);
    check("R4 other vpn miss", pack(h, f, p, u, d), 64'd0);
    refill(20'h00077, 4'd1, 1'b1, 20'h00100, 1'b1, 1'b1);
    probe(32'h0007_7FFF, 1'b0, 4'd9, h, f, p, u, d);
    check("R2 global any asid", pack(h, f, p, u, d), pack(1, 0, 32'h0010_0FFF, 0, 0));
  endtask

  task automatic t_perm();
    logic h, f, u, d; logic [PA_W-1:0] p;
    flush();
    refill(20'h00A00, 4'd2, 1'b0, 20'h55555, 1'b1, 1'b0);
    refill(20'h00B00, 4'd2, 1'b0, 20'h66666, 1'b0, 1'b1);
    probe(32'h00A0_0010, 1'b0, 4'd2, h, f, p, u, d);
    check("R3 read allowed", pack(h, f, p, u, d), pack(1, 0, 32'h5555_5010, 0, 0));
    probe(32'h00A0_0010, 1'b1, 4'd2, h, f, p, u, d);
    check("R3 write fault R5 used shown", pack(h, f, p, u, d), pack(0, 1, 0, 1, 0));
    probe(32'h00B0_0020, 1'b0, 4'd2, h, f, p, u, d);
    check("R3 read fault", pack(h, f, p, u, d), pack(0, 1, 0, 0, 0));
    probe(32'h00B0_0020, 1'b1, 4'd2, h, f, p, u, d);
    check("R3 write allowed R6 fault left used", pack(h, f, p, u, d),
          pack(1, 0, 32'h6666_6020, 0, 0));
  endtask

  task automatic t_status();
    logic h, f, u, d; logic [PA_W-1:0] p;
    flush();
    // R7: refill and lookup of the same page in one cycle
    rf_en = 1'b1; rf_vpn = 20'h00C00; rf_asid = 4'd2; rf_global = 1'b0;
    rf_pfn = 20'h0C0C0; rf_rd_ok = 1'b1; rf_wr_ok = 1'b1;
    lk_en = 1'b1; lk_va = 32'h00C0_0004; lk_write = 1'b0; cur_asid = 4'd2;
    #1;
    check("R7 not visible same cycle", {63'd0, lk_hit}, 64'd0);
    @(posedge clk); @(negedge clk);
    rf_en = 1'b0; lk_en = 1'b0;
    probe(32'h00C0_0004, 1'b0, 4'd2, h, f, p, u, d);
    check("R7 visible next cycle", pack(h, f, p, u, d), pack(1, 0, 32'h0C0C_0004, 0, 0));
    probe(32'h00C0_0004, 1'b1, 4'd2, h, f, p, u, d);
    check("R6 read set used", pack(h, f, p, u, d), pack(1, 0, 32'h0C0C_0004, 1, 0));
    probe(32'h00C0_0004, 1'b0, 4'd2, h, f, p, u, d);
    check("R6 write set dirty", pack(h, f, p, u, d), pack(1, 0, 32'h0C0C_0004, 1, 1));
    refill(20'h00C00, 4'd2, 1'b0, 20'h0D0D0, 1'b1, 1'b1);
    probe(32'h00C0_0004, 1'b0, 4'd2, h, f, p, u, d);
    check("R7 refill clean status", pack(h, f, p, u, d), pack(1, 0, 32'h0D0D_0004, 0, 0));
    // R6: a write fault changes nothing
    refill(20'h00D00, 4'd2, 1'b0, 20'h0E0E0, 1'b1, 1'b0);
    probe(32'h00D0_0000, 1'b1, 4'd2, h, f, p, u, d);
    probe(32'h00D0_0000, 1'b0, 4'd2, h, f, p, u, d);
    check("R6 fault kept used dirty", pack(h, f, p, u, d), pack(1, 0, 32'h0E0E_0000, 0, 0));
  endtask

  task automatic t_enable_gate();
    logic h, f, u, d; logic [PA_W-1:0] p;
    flush();
    refill(20'h00E00, 4'd1, 1'b0, 20'h0F0F0, 1'b1, 1'b1);
    lk_en = 1'b0; lk_va = 32'h00E0_0001; lk_write = 1'b1; cur_asid = 4'd1;
    #1;
    check("R4 disabled outputs", pack(lk_hit, lk_fault, lk_pa, lk_used, lk_dirty), 64'd0);
    @(posedge clk); @(negedge clk);
    probe(32'h00E0_0001, 1'b0, 4'd1, h, f, p, u, d);
    check("R4 disabled no touch", pack(h, f, p, u, d), pack(1, 0, 32'h0F0F_0001, 0, 0));
  endtask

  task automatic t_overlap();
    logic h, f, u, d; logic [PA_W-1:0] p;
    int hits;
    flush();
    for (int k = 0; k < 4; k++) refill(20'h10000 + 20'(k), 4'd1, 1'b0, 20'h20000 + 20'(k), 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) refill(20'h10000, 4'd1, 1'b0, 20'h30000 + 20'(k), 1'b1, 1'b1);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      probe(32'h1000_0000 + (32'(k) << 12), 1'b0, 4'd1, h, f, p, u, d);
      if (h) hits++;
    end
    check("R8 rewrite evicts none", 64'(hits), 64'd4);
    probe(32'h1000_0123, 1'b0, 4'd1, h, f, p, u, d);
    check("R8 latest frame", {31'd0, h, p}, {31'd0, 1'b1, 32'h3000_2123});
    // global replacing two per-ASID copies
    flush();
    refill(20'h40000, 4'd1, 1'b0, 20'h41000, 1'b1, 1'b1);
    refill(20'h40000, 4'd2, 1'b0, 20'h42000, 1'b1, 1'b1);
    refill(20'h40000, 4'd5, 1'b1, 20'h4F000, 1'b1, 1'b1);
    probe(32'h4000_0008, 1'b0, 4'd2, h, f, p, u, d);
    check("R8 global replaced asid2", {31'd0, h, p}, {31'd0, 1'b1, 32'h4F00_0008});
    probe(32'h4000_0008, 1'b0, 4'd1, h, f, p, u, d);
    check("R8 global replaced asid1", {31'd0, h, p}, {31'd0, 1'b1, 32'h4F00_0008});
    // R9: three slots freed, filling them keeps the global page
    for (int k = 1; k < 4; k++) refill(20'h50000 + 20'(k), 4'd3, 1'b0, 20'h51000 + 20'(k), 1'b1, 1'b1);
    hits = 0;
    for (int k = 1; k < 4; k++) begin
      probe(32'h5000_0000 + (32'(k) << 12), 1'b0, 4'd3, h, f, p, u, d);
      if (h) hits++;
    end
    probe(32'h4000_0000, 1'b0, 4'd3, h, f, p, u, d);
    if (h) hits++;
    check("R9 vacancies filled first", 64'(hits), 64'd4);
  endtask

  task automatic t_random();
    logic h, f, u, d; logic [PA_W-1:0] p;
    int hits;
    flush();
    for (int k = 0; k < 4; k++) refill(20'h60000 + 20'(k), 4'd6, 1'b0, 20'h61000 + 20'(k), 1'b1, 1'b1);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      probe(32'h6000_0000 + (32'(k) << 12), 1'b0, 4'd6, h, f, p, u, d);
      if (h) hits++;
    end
    check("R9 fill all four", 64'(hits), 64'd4);
    refill(20'h6F000, 4'd6, 1'b0, 20'h6F6F6, 1'b1, 1'b1);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      probe(32'h6000_0000 + (32'(k) << 12), 1'b0, 4'd6, h, f, p, u, d);
      if (h) hits++;
    end
    check("R10 one evicted", 64'(hits), 64'd3);
    probe(32'h6F00_0ABC, 1'b0, 4'd6, h, f, p, u, d);
    check("R10 new page resident", {31'd0, h, p}, {31'd0, 1'b1, 32'h6F6F_6ABC});
  endtask

  task automatic t_invalidate();
    logic h, f, u, d; logic [PA_W-1:0] p;
    flush();
    refill(20'h70001, 4'd1, 1'b0, 20'h71001, 1'b1, 1'b1);
    refill(20'h70002, 4'd2, 1'b0, 20'h71002, 1'b1, 1'b1);
    refill(20'h70003, 4'd1, 1'b1, 20'h71003, 1'b1, 1'b1);
    inv_asid_en = 1'b1; inv_asid = 4'd1;
    @(posedge clk); @(negedge clk);
    inv_asid_en = 1'b0;
    probe(32'h7000_1000, 1'b0, 4'd1, h, f, p, u, d);
    check("R12 asid1 cleared", {62'd0, h, f}, 64'd0);
    probe(32'h7000_2000, 1'b0, 4'd2, h, f, p, u, d);
    check("R12 asid2 kept", {63'd0, h}, 64'd1);
    probe(32'h7000_3000, 1'b0, 4'd1, h, f, p, u, d);
    check("R12 global kept", {63'd0, h}, 64'd1);
    // R13 with inv_asid_en
    inv_asid_en = 1'b1; inv_asid = 4'd2;
    rf_en = 1'b1; rf_vpn = 20'h70004; rf_asid = 4'd7; rf_global = 1'b0;
    rf_pfn = 20'h71004; rf_rd_ok = 1'b1; rf_wr_ok = 1'b1;
    @(posedge clk); @(negedge clk);
    inv_asid_en = 1'b0; rf_en = 1'b0;
    probe(32'h7000_4000, 1'b0, 4'd7, h, f, p, u, d);
    check("R13 refill dropped by asid flush", {63'd0, h}, 64'd0);
    probe(32'h7000_2000, 1'b0, 4'd2, h, f, p, u, d);
    check("R12 asid2 now cleared", {63'd0, h}, 64'd0);
    // R11 with concurrent refill (R13)
    inv_all = 1'b1;
    rf_en = 1'b1; rf_vpn = 20'h70005; rf_asid = 4'd1; rf_global = 1'b1;
    @(posedge clk); @(negedge clk);
    inv_all = 1'b0; rf_en = 1'b0;
    probe(32'h7000_3000, 1'b0, 4'd1, h, f, p, u, d);
    check("R11 global cleared", {62'd0, h, f}, 64'd0);
    probe(32'h7000_5000, 1'b0, 4'd1, h, f, p, u, d);
    check("R13 refill dropped by full flush", {62'd0, h, f}, 64'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cur_asid = '0; lk_en = 1'b0; lk_write = 1'b0; lk_va = '0;
    rf_en = 1'b0; rf_vpn = '0; rf_asid = '0; rf_global = 1'b0; rf_pfn = '0;
    rf_rd_ok = 1'b0; rf_wr_ok = 1'b0; inv_all = 1'b0; inv_asid_en = 1'b0; inv_asid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_translate();
    t_perm();
    t_status();
    t_enable_gate();
    t_overlap();
    t_random();
    t_invalidate();
    finish_run();
  end

endmodule